// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Bank

This block receives message-signalled interrupts. A bus master posts an interrupt by writing a vector number to one doorbell register. The block splits that number into a status-register index and a bit position, then sets that bit. Every status register drives its own active-high interrupt line toward an upstream interrupt controller. The line is high while any bit of its register is pending.

Software services a line by reading the matching status register. The read returns the pending bits and clears the same bits, so no separate acknowledge write is needed. A bit posted in the same cycle as the clearing read stays pending and is reported by the next read. The register port is a simple 32-bit interface with separate write and read strobes, so a doorbell write and a status read can happen in the same cycle.

A parameter selects one of two address maps. The wide map spaces the status registers 16 bytes apart. The dense map packs them 4 bytes apart. Each map places the doorbell at a different offset.

Top module: `msi_doorbell_bank`

## Requirements
- R1: A doorbell write of vector n, with n below 256, sets bit (n mod 32) of status register (n div 32). Earlier pending bits in that register are kept, and other registers do not change.
- R2: The doorbell sits at byte offset 0x140 in the wide map (MAP = MAP_WIDE, value 0) and at byte offset 0x38 in the dense map (MAP = MAP_DENSE, value 1). A write of a vector to the doorbell offset of the other map posts nothing.
- R3: Status register i is read at byte offset i*0x10 in the wide map and at byte offset i*0x4 in the dense map, for i from 0 to 7.
- R4: A read of a status register returns its content on rd_data in the cycle after rd_en is sampled. The same read clears every bit it returned, so an immediate second read returns zero.
- R5: When a doorbell write sets a bit in the same cycle that a read clears the same register, the read returns the content from before the write. The newly set bit stays pending afterwards.
- R6: irq_out[i] is high exactly when status register i held a nonzero value at the previous clock edge. It rises one cycle after the doorbell write that set the bit has taken effect.
- R7: A doorbell write whose data value is 256 or greater (including values with bit 31 set) changes no status bit and no interrupt line.
- R8: A read from any offset that is not a status register, including the doorbell, returns zero and clears nothing. A write to any offset other than the doorbell changes no state.
- R9: While rst_n is low, all status bits and all interrupt lines are cleared. This holds at start-up and when reset is applied in mid-run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data; at the doorbell this is the vector number |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_en |
| irq_out | output | 8 | One active-high interrupt line per status register |

## Verification
The bench builds two copies of the block side by side. One uses the wide map and the other the dense map, so both doorbell offsets and both register strides are covered in one run. Each copy is also probed at the other map's doorbell offset, which shows that the map choice really moves the doorbell. Both copies use the default 8 registers of 32 bits, so the vector values 255, 256 and 2^31 and the top bit of the last register can all be reached with the bench's own mod/div arithmetic.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;

  typedef enum logic {
    MAP_WIDE  = 1'b0,
    MAP_DENSE = 1'b1
  } map_e;

  function automatic int unsigned doorbell_offset(map_e m);
    return (m == MAP_WIDE) ? 32'h140 : 32'h38;
  endfunction

  function automatic int unsigned status_stride(map_e m);
    return (m == MAP_WIDE) ? 32'd16 : 32'd4;
  endfunction

  function automatic int unsigned status_offset(map_e m, int unsigned idx);
    return idx * status_stride(m);
  endfunction

  function automatic int unsigned vector_reg(int unsigned v, int unsigned bits);
    return v / bits;
  endfunction

  function automatic int unsigned vector_bit(int unsigned v, int unsigned bits);
    return v % bits;
  endfunction

  function automatic logic vector_in_range(int unsigned v, int unsigned total);
    return v < total;
  endfunction

endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
  import msi_bank_pkg::*;
#(
  parameter int   ADDR_W   = 12,
  parameter int   NUM_REGS = 8,
  parameter int   IDX_W    = 3,
  parameter map_e MAP      = MAP_WIDE
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              door_hit,
  output logic              rd_hit,
  output logic [IDX_W-1:0]  rd_idx
);

  localparam int unsigned DOOR_OFF = doorbell_offset(MAP);

  logic [NUM_REGS-1:0] rd_sel;

  assign door_hit = wr_en && (wr_addr == ADDR_W'(DOOR_OFF));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_rsel
    localparam int unsigned REG_OFF = status_offset(MAP, g);
    assign rd_sel[g] = rd_en && (rd_addr == ADDR_W'(REG_OFF));
  end

  assign rd_hit = |rd_sel;

  always_comb begin
    rd_idx = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_sel[i]) rd_idx = rd_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/msi_vector_decode.sv
module msi_vector_decode
  import msi_bank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3,
  parameter int BIT_W    = 5
) (
  input  logic              door_hit,
  input  logic [DATA_W-1:0] wr_data,
  output logic              set_valid,
  output logic [IDX_W-1:0]  set_idx,
  output logic [BIT_W-1:0]  set_bit
);

  localparam int unsigned TOTAL = NUM_REGS * DATA_W;

  assign set_valid = door_hit && vector_in_range(wr_data, TOTAL);
  assign set_idx   = IDX_W'(vector_reg(wr_data, DATA_W));
  assign set_bit   = BIT_W'(vector_bit(wr_data, DATA_W));

endmodule

// File: rtl/msi_status_slice.sv
module msi_status_slice #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_mask,
  input  logic              clr_en,
  output logic [DATA_W-1:0] status,
  output logic              irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (clr_en ? '0 : status) | set_mask;
      irq    <= |status;
    end
  end

endmodule

// File: rtl/msi_doorbell_bank.sv
module msi_doorbell_bank
  import msi_bank_pkg::*;
#(
  parameter int   NUM_REGS = 8,
  parameter int   DATA_W   = 32,
  parameter int   ADDR_W   = 12,
  parameter map_e MAP      = MAP_WIDE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_REGS-1:0] irq_out
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic                              door_hit;
  logic                              rd_hit;
  logic [IDX_W-1:0]                  rd_idx;
  logic                              set_valid;
  logic [IDX_W-1:0]                  set_idx;
  logic [BIT_W-1:0]                  set_bit;
  logic [NUM_REGS-1:0][DATA_W-1:0]   set_mask;
  logic [NUM_REGS-1:0]               clr_en;
  logic [NUM_REGS-1:0][DATA_W-1:0]   status_q;
  logic [DATA_W-1:0]                 rd_word;
  logic [DATA_W-1:0]                 rd_data_q;

  msi_addr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .MAP      (MAP)
  ) u_addr_decode (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .door_hit (door_hit),
    .rd_hit   (rd_hit),
    .rd_idx   (rd_idx)
  );

  msi_vector_decode #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .BIT_W    (BIT_W)
  ) u_vector_decode (
    .door_hit  (door_hit),
    .wr_data   (wr_data),
    .set_valid (set_valid),
    .set_idx   (set_idx),
    .set_bit   (set_bit)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slice
    assign set_mask[g] = (set_valid && (set_idx == IDX_W'(g)))
                         ? (DATA_W'(1) << set_bit) : '0;
    assign clr_en[g]   = rd_hit && (rd_idx == IDX_W'(g));

    msi_status_slice #(
      .DATA_W (DATA_W)
    ) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_mask[g]),
      .clr_en   (clr_en[g]),
      .status   (status_q[g]),
      .irq      (irq_out[g])
    );
  end

  assign rd_word = rd_hit ? status_q[rd_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_q <= '0;
    else        rd_data_q <= rd_en ? rd_word : '0;
  end

  assign rd_data = rd_data_q;

endmodule

// File: rtl/msi_doorbell_bank_checker.sv
module msi_doorbell_bank_checker #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              wr_en,
  input logic [DATA_W-1:0]                 wr_data,
  input logic                              rd_en,
  input logic [DATA_W-1:0]                 rd_data,
  input logic [NUM_REGS-1:0]               irq_out,
  input logic                              door_hit,
  input logic                              set_valid,
  input logic [((NUM_REGS > 1) ? $clog2(NUM_REGS) : 1)-1:0] set_idx,
  input logic [((DATA_W > 1) ? $clog2(DATA_W) : 1)-1:0]     set_bit,
  input logic                              rd_hit,
  input logic [((NUM_REGS > 1) ? $clog2(NUM_REGS) : 1)-1:0] rd_idx,
  input logic [NUM_REGS-1:0][DATA_W-1:0]   status_q
);

  localparam int unsigned TOTAL = NUM_REGS * DATA_W;

  // R1: a posted vector is pending after the edge that takes it
  assert_vector_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> status_q[$past(set_idx)][$past(set_bit)]);

  // R4: read data equals the register content at the read edge
  assert_read_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> rd_data == $past(status_q[rd_idx]));

  // R4: a read with no concurrent set leaves the register empty
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !(set_valid && set_idx == rd_idx)) |=> status_q[$past(rd_idx)] == '0);

  // R5: a set racing a clearing read survives alone
  assert_set_survives_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && set_valid && set_idx == rd_idx)
      |=> status_q[$past(rd_idx)] == (DATA_W'(1) << $past(set_bit)));

  // R7: out-of-range vectors post nothing
  assert_range_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && door_hit && wr_data >= DATA_W'(TOTAL)) |-> !set_valid);

  // R8: only the doorbell can post
  assert_only_doorbell_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !door_hit |-> !set_valid);

  // R8: unmapped reads return zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> rd_data == '0);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_irq
    // R6: each line is the registered OR of its register
    assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_out[g] == (|$past(status_q[g])));
  end

endmodule

bind msi_doorbell_bank msi_doorbell_bank_checker #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .irq_out   (irq_out),
  .door_hit  (door_hit),
  .set_valid (set_valid),
  .set_idx   (set_idx),
  .set_bit   (set_bit),
  .rd_hit    (rd_hit),
  .rd_idx    (rd_idx),
  .status_q  (status_q)
);

// File: tb/msi_doorbell_bank_bench.sv
`timescale 1ns/1ps
module msi_doorbell_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_s   [2];
  logic [11:0] wr_addr_s [2];
  logic [31:0] wr_data_s [2];
  logic        rd_en_s   [2];
  logic [11:0] rd_addr_s [2];
  logic [31:0] rd_data_s [2];
  logic [7:0]  irq_s     [2];

  bit [31:0] model [2][8];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  msi_doorbell_bank #(.MAP(msi_bank_pkg::MAP_WIDE)) u_msi_doorbell_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_s[0]), .wr_addr(wr_addr_s[0]), .wr_data(wr_data_s[0]),
    .rd_en(rd_en_s[0]), .rd_addr(rd_addr_s[0]), .rd_data(rd_data_s[0]),
    .irq_out(irq_s[0])
  );

  msi_doorbell_bank #(.MAP(msi_bank_pkg::MAP_DENSE)) u_msi_doorbell_bank_dense (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_s[1]), .wr_addr(wr_addr_s[1]), .wr_data(wr_data_s[1]),
    .rd_en(rd_en_s[1]), .rd_addr(rd_addr_s[1]), .rd_data(rd_data_s[1]),
    .irq_out(irq_s[1])
  );

  function automatic int db_off(int l);
    return (l == 0) ? 320 : 56;
  endfunction

  function automatic int stride(int l);
    return (l == 0) ? 16 : 4;
  endfunction

  function automatic int reg_at(int l, int addr);
    for (int i = 0; i < 8; i++) if (addr == i * stride(l)) return i;
    return -1;
  endfunction

  function automatic logic [7:0] exp_irq(int l);
    logic [7:0] e;
    for (int i = 0; i < 8; i++) e[i] = (model[l][i] != 0);
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic op(int l, bit we, int wa, logic [31:0] wd, bit re, int ra, string req);
    int idx;
    logic [31:0] exp;
    @(negedge clk);
    check(irq_s[l] == exp_irq(l), "R6", "irq lines",
          longint'(irq_s[l]), longint'(exp_irq(l)));
    wr_en_s[l] = we; wr_addr_s[l] = 12'(wa); wr_data_s[l] = wd;
    rd_en_s[l] = re; rd_addr_s[l] = 12'(ra);
    @(negedge clk);
    wr_en_s[l] = 1'b0; rd_en_s[l] = 1'b0;
    if (re) begin
      idx = reg_at(l, ra);
      exp = (idx >= 0) ? model[l][idx] : 32'h0;
      check(rd_data_s[l] == exp, req, "read data",
            longint'(rd_data_s[l]), longint'(exp));
      if (idx >= 0) model[l][idx] = 32'h0;
    end
    if (we && wa == db_off(l) && wd < 32'd256)
      model[l][wd[7:5]][wd[4:0]] = 1'b1;
  endtask

  task automatic ring(int l, logic [31:0] n, string req);
    op(l, 1'b1, db_off(l), n, 1'b0, 0, req);
  endtask

  task automatic rd(int l, int i, string req);
    op(l, 1'b0, 0, 32'h0, 1'b1, i * stride(l), req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int l = 0; l < 2; l++) begin
      wr_en_s[l] = 1'b0; rd_en_s[l] = 1'b0;
      wr_addr_s[l] = '0; rd_addr_s[l] = '0; wr_data_s[l] = '0;
      for (int i = 0; i < 8; i++) model[l][i] = 32'h0;
    end
    repeat (3) @(negedge clk);
    for (int l = 0; l < 2; l++)
      check(irq_s[l] == 8'h0, "R9", "irq in reset", longint'(irq_s[l]), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    do_reset();
    for (int l = 0; l < 2; l++) begin
      // R9: everything empty after reset
      for (int i = 0; i < 8; i++) rd(l, i, "R9");

      // R1: bits accumulate in one register, top vector lands at reg 7 bit 31
      ring(l, 3, "R1"); ring(l, 17, "R1"); ring(l, 31, "R1"); ring(l, 17, "R1");
      rd(l, 0, "R1");
      ring(l, 255, "R1");
      rd(l, 7, "R1");
      check(model[l][7] == 32'h0, "R1", "model consumed", 0, 0);

      // R2: the other map's doorbell offset posts nothing
      op(l, 1'b1, db_off(1 - l), 32'd40, 1'b0, 0, "R2");
      rd(l, 1, "R2");
      ring(l, 40, "R2");
      rd(l, 1, "R2");

      // R3: every register at its stride
      for (int i = 0; i < 8; i++) ring(l, 32'(i * 32 + (i * 5) % 32), "R3");
      for (int i = 0; i < 8; i++) rd(l, i, "R3");

      // R7: out-of-range vectors
      ring(l, 256, "R7"); ring(l, 300, "R7");
      ring(l, 32'hFFFF_FFFF, "R7"); ring(l, 32'h8000_0000, "R7");
      for (int i = 0; i < 8; i++) rd(l, i, "R7");

      // R5: set and clearing read in the same cycle
      ring(l, 70, "R5");
      op(l, 1'b1, db_off(l), 32'd72, 1'b1, 2 * stride(l), "R5");
      rd(l, 2, "R5");

      // R8: writes elsewhere and unmapped reads
      ring(l, 100, "R8");
      op(l, 1'b1, 3 * stride(l), 32'hFFFF_FFFF, 1'b0, 0, "R8");
      op(l, 1'b1, 260, 32'd5, 1'b0, 0, "R8");
      op(l, 1'b0, 0, 32'h0, 1'b1, 8 * stride(l), "R8");
      op(l, 1'b0, 0, 32'h0, 1'b1, db_off(l), "R8");
      op(l, 1'b0, 0, 32'h0, 1'b1, 2, "R8");
      rd(l, 3, "R8");

      // R6: one-cycle lag of the line after the set
      ring(l, 130, "R6");
      check(irq_s[l][4] == 1'b0, "R6", "line before lag", longint'(irq_s[l][4]), 0);
      @(negedge clk);
      check(irq_s[l][4] == 1'b1, "R6", "line after lag", longint'(irq_s[l][4]), 1);

      // R4: a read clears, the second read is empty
      ring(l, 200, "R4");
      rd(l, 6, "R4");
      rd(l, 6, "R4");
      rd(l, 4, "R4");
    end

    // random mix on both maps
    for (int it = 0; it < 1200; it++) begin
      int l, k, n, i;
      l = it % 2;
      k = int'($urandom % 10);
      n = int'($urandom % 288);
      i = int'($urandom % 8);
      if (k < 5)       ring(l, 32'(n), "R1");
      else if (k < 8)  rd(l, i, "R4");
      else if (k == 8) op(l, 1'b1, db_off(l), 32'(n), 1'b1, i * stride(l), "R5");
      else             op(l, 1'b1, int'($urandom % 512) & ~3, 32'(n),
                          1'b1, int'($urandom % 512) & ~3, "R8");
    end

    // R9: reset in mid-run
    ring(0, 9, "R9"); ring(1, 77, "R9"); ring(1, 250, "R9");
    do_reset();
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < 8; i++) rd(l, i, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule